// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block sits on the target side of a bus bridge. It checks each address that an external bus master presents against three programmable memory windows. When an address falls inside a window, the block reports a hit, the number of the window, and the address translated into system memory. On the system side every window starts at address zero, so the translated address is the offset of the request inside its window.

Each window is set by one 32-bit register word, written through a simple write port. The upper twelve bits give the window base, which is aligned to 1 MB. A 4-bit logarithmic code sets the window size, which is a power of two from 1 MB to 2 GB. A window whose code is out of range is switched off. Firmware programs the windows once, and the block then answers every request one clock cycle later.

Top module: `inwin_decoder`

## Requirements
- R1: After reset every window is switched off (base zero, size code 0xF). No request hits, and the response outputs are all zero until the first request.
- R2: A write with `cfg_we` high and `cfg_sel` equal to 0, 1 or 2 replaces that window's setting at the clock edge. A request sampled at that same edge still sees the old setting. A write with `cfg_sel` equal to 3 changes no window.
- R3: In the write word, bits 31:20 hold the window base in 1 MB units and bits 19:16 hold the size code. Bits 15:0 are discarded, so the kept base always has zero bits below bit 20.
- R4: Size codes 0 to 11 give a window size of 1 MB shifted left by the code, which spans 1 MB up to 2 GB.
- R5: Size codes 12 to 15 switch the window off, and it never hits.
- R6: A request hits a window when the request address and the base agree in every bit above the window size. A base that is not aligned to the window size therefore acts as if it were aligned down to that size.
- R7: On a hit, `rsp_addr` equals the request address minus the aligned window base.
- R8: When more than one window matches, the window with the lowest number is reported.
- R9: On a miss, `rsp_hit` is 0, `rsp_idx` is 0 and `rsp_addr` is 0.
- R10: `rsp_valid` is high in exactly the cycle after a cycle in which `req_valid` was high. While `rsp_valid` is low, `rsp_hit`, `rsp_idx` and `rsp_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_sel | input | 2 | Window number to write (0 to 2; 3 is ignored) |
| cfg_wdata | input | 32 | Window word: base in bits 31:20, size code in bits 19:16 |
| req_valid | input | 1 | Inbound request present |
| req_addr | input | 32 | Inbound bus address |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Request fell inside an enabled window |
| rsp_idx | output | 2 | Number of the winning window |
| rsp_addr | output | 32 | Translated system address (offset inside the window) |

## Verification
The assertions assume that `req_valid` and the window settings are free of X after reset. The priority and disable checks also assume that a window write and the request it is meant to affect never fall in the same cycle. The bench normally keeps writes and requests in separate cycles. It overlaps them exactly once, in the cycle that checks the old setting is used, and the expected value there is a miss, which is consistent with the assertions. All stimulus is driven on the falling edge, so every input is stable at each rising edge.

// File: rtl/inwin_pkg.sv
package inwin_pkg;
    // Default geometry of the window decoder
    localparam int unsigned INW_ADDR_W   = 32;
    localparam int unsigned INW_BASE_LSB = 20;  // 1 MB granularity
    localparam int unsigned INW_CODE_W   = 4;
    localparam int unsigned INW_CODE_LSB = 16;
    localparam int unsigned INW_NUM_WIN  = 3;
endpackage

// File: rtl/inwin_regs.sv
module inwin_regs #(
    parameter int unsigned NUM_WIN  = 3,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BASE_LSB = 20,
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned CODE_LSB = 16,
    parameter int unsigned SEL_W    = 2,
    parameter int unsigned BASE_W   = ADDR_W - BASE_LSB
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [SEL_W-1:0]                   cfg_sel,
    input  logic [ADDR_W-1:0]                  cfg_wdata,
    output logic [NUM_WIN-1:0][BASE_W-1:0]     win_base_o,
    output logic [NUM_WIN-1:0][CODE_W-1:0]     win_code_o
);
    typedef struct packed {
        logic [NUM_WIN-1:0][BASE_W-1:0] base;
        logic [NUM_WIN-1:0][CODE_W-1:0] code;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (cfg_we) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (cfg_sel == SEL_W'(i)) begin
                    // low base bits are dropped here: only the 1 MB part is kept
                    bank_d.base[i] = cfg_wdata[ADDR_W-1:BASE_LSB];
                    bank_d.code[i] = cfg_wdata[CODE_LSB +: CODE_W];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.base <= '0;
            bank_q.code <= '1;   // all-ones code: window switched off
        end else begin
            bank_q <= bank_d;
        end
    end

    assign win_base_o = bank_q.base;
    assign win_code_o = bank_q.code;

    AST_BAD_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (32'(cfg_sel) >= NUM_WIN)) |=> $stable(bank_q)); // R2

    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> (bank_q.code == '1)); // R1
endmodule

// File: rtl/inwin_match.sv
module inwin_match #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned BASE_LSB = 20,
    parameter int unsigned CODE_W   = 4,
    parameter int unsigned MAX_CODE = 11,
    parameter int unsigned BASE_W   = ADDR_W - BASE_LSB
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] offset_o
);
    logic              win_en;
    logic [ADDR_W-1:0] span_mask;
    logic [ADDR_W-1:0] base_full;

    always_comb begin
        win_en    = (32'(code_i) <= MAX_CODE);
        span_mask = win_en ? ((ADDR_W'(1) << (BASE_LSB + 32'(code_i))) - ADDR_W'(1))
                           : '0;
        base_full = {base_i, {BASE_LSB{1'b0}}};
        // bits inside the window span are ignored, which aligns the base down
        hit_o     = win_en && (((addr_i ^ base_full) & ~span_mask) == '0);
        offset_o  = hit_o ? (addr_i & span_mask) : '0;
    end
endmodule

// File: rtl/inwin_pick.sv
module inwin_pick #(
    parameter int unsigned NUM_WIN = 3,
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned IDX_W   = 2
) (
    input  logic [NUM_WIN-1:0]             hit_vec_i,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] offs_i,
    output logic                           any_hit_o,
    output logic [IDX_W-1:0]               idx_o,
    output logic [ADDR_W-1:0]              addr_o
);
    always_comb begin
        any_hit_o = 1'b0;
        idx_o     = '0;
        addr_o    = '0;
        // walk from the top so the lowest-numbered hit is written last
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec_i[i]) begin
                any_hit_o = 1'b1;
                idx_o     = IDX_W'(i);
                addr_o    = offs_i[i];
            end
        end
    end
endmodule

// File: rtl/inwin_decoder.sv
module inwin_decoder
    import inwin_pkg::*;
#(
    parameter int unsigned NUM_WIN  = INW_NUM_WIN,
    parameter int unsigned ADDR_W   = INW_ADDR_W,
    parameter int unsigned BASE_LSB = INW_BASE_LSB,
    parameter int unsigned CODE_W   = INW_CODE_W,
    parameter int unsigned CODE_LSB = INW_CODE_LSB,
    parameter int unsigned IDX_W    = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [IDX_W-1:0]  rsp_idx,
    output logic [ADDR_W-1:0] rsp_addr
);
    localparam int unsigned BASE_W   = ADDR_W - BASE_LSB;
    localparam int unsigned MAX_CODE = ADDR_W - BASE_LSB - 1;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
    } rsp_t;

    logic [NUM_WIN-1:0][BASE_W-1:0] win_base;
    logic [NUM_WIN-1:0][CODE_W-1:0] win_code;
    logic [NUM_WIN-1:0]             hit_vec;
    logic [NUM_WIN-1:0][ADDR_W-1:0] offs;
    logic                           pick_hit;
    logic [IDX_W-1:0]               pick_idx;
    logic [ADDR_W-1:0]              pick_addr;
    logic                           all_off;
    rsp_t                           rsp_d, rsp_q;

    inwin_regs #(
        .NUM_WIN (NUM_WIN),
        .ADDR_W  (ADDR_W),
        .BASE_LSB(BASE_LSB),
        .CODE_W  (CODE_W),
        .CODE_LSB(CODE_LSB),
        .SEL_W   (IDX_W),
        .BASE_W  (BASE_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .win_base_o(win_base),
        .win_code_o(win_code)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        inwin_match #(
            .ADDR_W  (ADDR_W),
            .BASE_LSB(BASE_LSB),
            .CODE_W  (CODE_W),
            .MAX_CODE(MAX_CODE),
            .BASE_W  (BASE_W)
        ) u_match (
            .base_i  (win_base[g]),
            .code_i  (win_code[g]),
            .addr_i  (req_addr),
            .hit_o   (hit_vec[g]),
            .offset_o(offs[g])
        );
    end

    inwin_pick #(
        .NUM_WIN(NUM_WIN),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_pick (
        .hit_vec_i(hit_vec),
        .offs_i   (offs),
        .any_hit_o(pick_hit),
        .idx_o    (pick_idx),
        .addr_o   (pick_addr)
    );

    always_comb begin
        all_off = 1'b1;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (32'(win_code[i]) <= MAX_CODE) all_off = 1'b0;
        end
    end

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.hit   = pick_hit;
            rsp_d.idx   = pick_idx;
            rsp_d.addr  = pick_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_idx   = rsp_q.idx;
    assign rsp_addr  = rsp_q.addr;

    AST_RESP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_idx == '0 && rsp_addr == '0)); // R10
    AST_MISS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_addr == '0)); // R9
    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (32'(rsp_idx) < NUM_WIN)); // R8
    AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit_vec[0]) |=> (rsp_hit && rsp_idx == '0)); // R8
    AST_OFFSET_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_addr[ADDR_W-1] == 1'b0)); // R4
    AST_ALL_OFF_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && all_off) |=> !rsp_hit); // R5
endmodule

// File: tb/inwin_decoder_test.sv
module inwin_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit;
    logic [1:0]  rsp_idx;
    logic [31:0] rsp_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    inwin_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
        .rsp_addr(rsp_addr)
    );

    task automatic check_rsp(input string req, input logic v, input logic h,
                             input logic [1:0] idx, input logic [31:0] a);
        n_chk++;
        if (rsp_valid !== v || rsp_hit !== h || rsp_idx !== idx || rsp_addr !== a) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b hit=%0b idx=%0d addr=%h, expected valid=%0b hit=%0b idx=%0d addr=%h",
                     req, rsp_valid, rsp_hit, rsp_idx, rsp_addr, v, h, idx, a);
        end
    endtask

    task automatic write_win(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic probe(input string req, input logic [31:0] addr, input logic h,
                         input logic [1:0] idx, input logic [31:0] off);
        @(negedge clk);
        req_valid = 1'b1; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(req, 1'b1, h, idx, off);
    endtask

    task automatic t_reset();
        check_rsp("R1 reset outputs", 1'b0, 1'b0, 2'd0, 32'h0);
        probe("R1 all windows off at 0", 32'h0000_0000, 1'b0, 2'd0, 32'h0);
        probe("R1 all windows off at 1000_0000", 32'h1000_0000, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_basic();
        // R3: junk in bits 15:0 is dropped; code 0 = 1 MB
        write_win(2'd0, 32'h1000_ABCD);
        probe("R3 window 0 low edge", 32'h1000_0000, 1'b1, 2'd0, 32'h0);
        probe("R7 window 0 top byte", 32'h100F_FFFF, 1'b1, 2'd0, 32'h000F_FFFF);
        probe("R9 above window 0", 32'h1010_0000, 1'b0, 2'd0, 32'h0);
        probe("R9 below window 0", 32'h0FFF_FFFF, 1'b0, 2'd0, 32'h0);
        // R10: the cycle after a request, with no new request
        @(negedge clk);
        check_rsp("R10 idle after request", 1'b0, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_sizes();
        write_win(2'd1, 32'h4003_0000);     // code 3 = 8 MB
        probe("R4 8MB last byte", 32'h407F_FFFF, 1'b1, 2'd1, 32'h007F_FFFF);
        probe("R4 8MB just past", 32'h4080_0000, 1'b0, 2'd0, 32'h0);
        write_win(2'd2, 32'h8034_5678);     // base 0x803, code 4 = 16 MB, misaligned
        probe("R6 misaligned base aligned down", 32'h8000_0010, 1'b1, 2'd2, 32'h0000_0010);
        probe("R6 misaligned top", 32'h80FF_FFFF, 1'b1, 2'd2, 32'h00FF_FFFF);
        probe("R6 past aligned window", 32'h8100_0000, 1'b0, 2'd0, 32'h0);
        write_win(2'd2, 32'h800B_0000);     // code 11 = 2 GB
        probe("R4 2GB top address", 32'hFFFF_FFFF, 1'b1, 2'd2, 32'h7FFF_FFFF);
        probe("R7 2GB offset", 32'h8100_0000, 1'b1, 2'd2, 32'h0100_0000);
    endtask

    task automatic t_disabled();
        write_win(2'd2, 32'h800C_0000);
        probe("R5 code 12 disables", 32'h8000_0000, 1'b0, 2'd0, 32'h0);
        write_win(2'd2, 32'h800F_0000);
        probe("R5 code 15 disables", 32'h8000_0000, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_priority();
        write_win(2'd0, 32'h4001_0000);     // 2 MB inside window 1
        probe("R8 overlap lowest wins", 32'h4000_1000, 1'b1, 2'd0, 32'h0000_1000);
        probe("R8 only window 1", 32'h4020_0000, 1'b1, 2'd1, 32'h0020_0000);
        probe("R9 past both", 32'h4080_0000, 1'b0, 2'd0, 32'h0);
    endtask

    task automatic t_writes();
        write_win(2'd3, 32'h2000_0000);
        probe("R2 sel 3 creates nothing", 32'h2000_0000, 1'b0, 2'd0, 32'h0);
        probe("R2 sel 3 leaves window 0", 32'h4000_1000, 1'b1, 2'd0, 32'h0000_1000);
        // write and request in the same cycle: the old window 0 applies
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h6000_0000;
        req_valid = 1'b1; req_addr = 32'h6000_0000;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check_rsp("R2 same-cycle write uses old value", 1'b1, 1'b0, 2'd0, 32'h0);
        probe("R2 new window 0 active", 32'h6000_0000, 1'b1, 2'd0, 32'h0);
        probe("R2 old window 0 gone", 32'h4000_1000, 1'b1, 2'd1, 32'h0000_1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_sizes();
        t_disabled();
        t_priority();
        t_writes();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule